// File: doc/BRIEF.md
# Completion Event Ring Writer

This block is the hardware producer of a circular ring of completion events that lives in system memory. Each time the transfer engine finishes a descriptor, it hands the block a completion code and a 4-bit error-info value over a valid/ready stream. The block turns that into a 16-byte event record and issues one memory-write request for it, at the ring base plus the current write offset. Once the memory side acknowledges the write without error, the write offset moves on by one record and a one-cycle end-of-block pulse goes to the interrupt logic.

Software sees the write offset on a plain output and programs the ring through a small register write port. The port holds the 64-bit ring base (two 32-bit halves), the ring length in bytes, and a doorbell that returns the offset software has consumed up to. When the next record would land on that read offset, the ring counts as full. The completion stream is then back-pressured until a doorbell write frees space.

Back-pressure rules: a completion transfers on a rising edge where `cmp_valid` and `cmp_ready` are both high. `cmp_ready` is low while a record is in flight and while the ring is full. The memory request transfers on an edge where `mw_valid` and `mw_ready` are both high. Once raised, `mw_valid` stays high and `mw_addr`/`mw_data` stay stable until that edge. Only one record is outstanding at a time. Its response is taken on the first edge with `rsp_valid` high after the request has transferred.

Top module: `evr_ring_writer`

## Requirements
- R1: After reset the write offset is 0, the read offset is 0, the ring length is RESET_LEN bytes, the base is 0, `cmp_ready` is 1, and `mw_valid`, `eob_pulse` and `werr_pulse` are 0.
- R2: Each record is 128 bits. Bits 31:28 hold the completion code (1 = success, 4 = failure, passed through unchanged), bits 27:24 hold the error-info nibble, and all other bits are 0. The record address is the ring base plus the write offset. The base low half is written at register offset 0x008 and the high half at 0x00C.
- R3: A response with `rsp_err` = 0 advances the write offset by 16 and raises `eob_pulse` for exactly one cycle. Both take effect on the edge that takes the response.
- R4: The ring length is written at offset 0x010 (bytes, low 4 bits ignored). When the write offset plus 16 reaches or passes the length, the new offset is that sum minus the length.
- R5: When the advanced write offset would equal the read offset, `cmp_ready` is 0 and no request is issued, however long `cmp_valid` is held.
- R6: A write at offset 0x400 sets the read offset to the written value with its low 4 bits cleared. A full ring accepts completions again once the read offset moves.
- R7: A response with `rsp_err` = 1 raises `werr_pulse` for one cycle, gives no `eob_pulse`, and leaves the write offset unchanged.
- R8: A raised `mw_valid` holds with stable address and data until `mw_ready`. `cmp_ready` stays low from acceptance until the response is taken.
- R9: Records are written in the order their completions were accepted.
- R10: Writes to any other offset, including an attempt to write the write offset at 0x020, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| wr_ptr | output | PTR_W | Current write offset in bytes |
| cmp_valid | input | 1 | Completion available |
| cmp_ready | output | 1 | Completion accepted this cycle when valid |
| cmp_code | input | 4 | Completion code |
| cmp_info | input | 4 | Error-info nibble |
| mw_valid | output | 1 | Memory write request valid |
| mw_ready | input | 1 | Memory side accepts the request |
| mw_addr | output | ADDR_W | Record byte address |
| mw_data | output | 128 | Record contents |
| rsp_valid | input | 1 | Write response valid |
| rsp_err | input | 1 | Write response carries an error |
| eob_pulse | output | 1 | One-cycle pulse per written record |
| werr_pulse | output | 1 | One-cycle pulse per failed record write |

## Verification
The bench builds the block with ADDR_W = 64, PTR_W = 16 and RESET_LEN = 64. A four-slot ring becomes full after three records and wraps on the fourth, so full stall, doorbell release and offset wrap all occur within a handful of events. It then sets the length to 96 bytes, which shows that wrap follows the programmed length rather than the reset value. A base with a non-zero high half checks that both address halves reach the request.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int REC_BYTES = 16;
  localparam int REC_BITS  = REC_BYTES * 8;
  localparam int REC_SHIFT = $clog2(REC_BYTES);

  localparam logic [11:0] REG_BASE_LO  = 12'h008;
  localparam logic [11:0] REG_BASE_HI  = 12'h00C;
  localparam logic [11:0] REG_LEN      = 12'h010;
  localparam logic [11:0] REG_DOORBELL = 12'h400;

  localparam int CODE_MSB = 31;
  localparam int CODE_LSB = 28;
  localparam int INFO_MSB = 27;
  localparam int INFO_LSB = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } wr_state_t;
endpackage

// File: rtl/evr_cfg_regs.sv
module evr_cfg_regs
  import evr_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PTR_W     = 16,
  parameter int RESET_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [11:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [ADDR_W-1:0] ring_base,
  output logic [PTR_W-1:0]  ring_len,
  output logic [PTR_W-1:0]  rd_off
);
  localparam int HI_W = ADDR_W - 32;

  logic [31:0]     base_lo;
  logic [HI_W-1:0] base_hi;
  logic [PTR_W-1:0] aligned_wdata;

  // offsets are always whole records: drop the low bits
  always_comb begin
    aligned_wdata = cfg_wdata[PTR_W-1:0];
    aligned_wdata[REC_SHIFT-1:0] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo  <= '0;
      base_hi  <= '0;
      ring_len <= PTR_W'(RESET_LEN);
      rd_off   <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_BASE_LO:  base_lo  <= cfg_wdata;
        REG_BASE_HI:  base_hi  <= cfg_wdata[HI_W-1:0];
        REG_LEN:      ring_len <= aligned_wdata;
        REG_DOORBELL: rd_off   <= aligned_wdata;
        default: ;
      endcase
    end
  end

  assign ring_base = {base_hi, base_lo};
endmodule

// File: rtl/evr_ptr_ctrl.sv
module evr_ptr_ctrl
  import evr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             err_seen,
  input  logic [PTR_W-1:0] ring_len,
  input  logic [PTR_W-1:0] rd_off,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             full
);
  logic [PTR_W:0]   sum;
  logic [PTR_W-1:0] nxt;

  always_comb begin
    sum = {1'b0, wr_ptr} + (PTR_W+1)'(REC_BYTES);
    if (sum >= {1'b0, ring_len}) nxt = PTR_W'(sum - {1'b0, ring_len});
    else                         nxt = PTR_W'(sum);
  end

  assign full = (nxt == rd_off);

  always_ff @(posedge clk) begin
    if (!rst_n)       wr_ptr <= '0;
    else if (advance) wr_ptr <= nxt;
  end

  // R1: the offset only ever moves in whole records
  a_r1_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr[REC_SHIFT-1:0] == '0);

  // R5: a record is never committed into a full ring
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !full);

  // R7: the cycle that reports a failed write shows an unmoved offset
  a_r7_err_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    err_seen |-> $stable(wr_ptr));
endmodule

// File: rtl/evr_write_fsm.sv
module evr_write_fsm
  import evr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PTR_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_valid,
  output logic                cmp_ready,
  input  logic [3:0]          cmp_code,
  input  logic [3:0]          cmp_info,
  input  logic                full,
  input  logic [ADDR_W-1:0]   ring_base,
  input  logic [PTR_W-1:0]    wr_ptr,
  output logic                mw_valid,
  input  logic                mw_ready,
  output logic [ADDR_W-1:0]   mw_addr,
  output logic [REC_BITS-1:0] mw_data,
  input  logic                rsp_valid,
  input  logic                rsp_err,
  output logic                advance,
  output logic                eob_pulse,
  output logic                werr_pulse
);
  wr_state_t state;
  logic [REC_BITS-1:0] rec;
  logic take_rsp;

  always_comb begin
    rec = '0;
    rec[CODE_MSB:CODE_LSB] = cmp_code;
    rec[INFO_MSB:INFO_LSB] = cmp_info;
  end

  assign cmp_ready = (state == ST_IDLE) && !full;
  assign mw_valid  = (state == ST_SEND);
  assign take_rsp  = (state == ST_WAIT) && rsp_valid;
  assign advance   = take_rsp && !rsp_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mw_addr    <= '0;
      mw_data    <= '0;
      eob_pulse  <= 1'b0;
      werr_pulse <= 1'b0;
    end else begin
      eob_pulse  <= take_rsp && !rsp_err;
      werr_pulse <= take_rsp && rsp_err;
      case (state)
        ST_IDLE: if (cmp_valid && cmp_ready) begin
          mw_addr <= ring_base + ADDR_W'(wr_ptr);
          mw_data <= rec;
          state   <= ST_SEND;
        end
        ST_SEND: if (mw_ready) state <= ST_WAIT;
        ST_WAIT: if (rsp_valid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: an offered request is held unchanged until taken
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  // R3: end-of-block lasts a single cycle
  a_r3_eob_single: assert property (@(posedge clk) disable iff (!rst_n)
    eob_pulse |=> !eob_pulse);

  // R7: a failed write never also reports success
  a_r7_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(eob_pulse && werr_pulse));
endmodule

// File: rtl/evr_ring_writer.sv
module evr_ring_writer
  import evr_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PTR_W     = 16,
  parameter int RESET_LEN = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [11:0]         cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [PTR_W-1:0]    wr_ptr,
  input  logic                cmp_valid,
  output logic                cmp_ready,
  input  logic [3:0]          cmp_code,
  input  logic [3:0]          cmp_info,
  output logic                mw_valid,
  input  logic                mw_ready,
  output logic [ADDR_W-1:0]   mw_addr,
  output logic [REC_BITS-1:0] mw_data,
  input  logic                rsp_valid,
  input  logic                rsp_err,
  output logic                eob_pulse,
  output logic                werr_pulse
);
  logic [ADDR_W-1:0] ring_base;
  logic [PTR_W-1:0]  ring_len;
  logic [PTR_W-1:0]  rd_off;
  logic              full;
  logic              advance;

  evr_cfg_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .RESET_LEN(RESET_LEN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ring_base(ring_base), .ring_len(ring_len),
    .rd_off(rd_off)
  );

  evr_ptr_ctrl #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .advance(advance), .err_seen(werr_pulse),
    .ring_len(ring_len), .rd_off(rd_off), .wr_ptr(wr_ptr), .full(full)
  );

  evr_write_fsm #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready),
    .cmp_code(cmp_code), .cmp_info(cmp_info), .full(full),
    .ring_base(ring_base), .wr_ptr(wr_ptr), .mw_valid(mw_valid),
    .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .advance(advance),
    .eob_pulse(eob_pulse), .werr_pulse(werr_pulse)
  );
endmodule

// File: tb/evr_ring_writer_test.sv
module evr_ring_writer_test;
  localparam int ADDR_W = 64;
  localparam int PTR_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [PTR_W-1:0] wr_ptr;
  logic cmp_valid = 1'b0;
  logic cmp_ready;
  logic [3:0] cmp_code = '0;
  logic [3:0] cmp_info = '0;
  logic mw_valid;
  logic mw_ready = 1'b0;
  logic [ADDR_W-1:0] mw_addr;
  logic [127:0] mw_data;
  logic rsp_valid = 1'b0;
  logic rsp_err = 1'b0;
  logic eob_pulse, werr_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [ADDR_W-1:0] m_base = '0;
  int m_len = 64;
  int m_wp = 0;
  logic [ADDR_W-1:0] q_addr[$];
  logic [127:0]      q_data[$];

  always #5 clk = ~clk;

  evr_ring_writer #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .RESET_LEN(64)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wr_ptr(wr_ptr), .cmp_valid(cmp_valid),
    .cmp_ready(cmp_ready), .cmp_code(cmp_code), .cmp_info(cmp_info),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .eob_pulse(eob_pulse), .werr_pulse(werr_pulse)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare each taken request with the oldest expectation (R2, R9)
  always @(negedge clk) begin
    if (rst_n && mw_valid && mw_ready) begin
      if (q_addr.size() == 0) begin
        chk(0, "R9 unexpected request", {64'h0, mw_addr}, 128'h0);
      end else begin
        chk(mw_addr == q_addr[0], "R2/R9 record address", {64'h0, mw_addr}, {64'h0, q_addr[0]});
        chk(mw_data == q_data[0], "R2/R9 record contents", mw_data, q_data[0]);
        void'(q_addr.pop_front());
        void'(q_data.pop_front());
      end
    end
  end

  task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic do_event(input logic [3:0] code, input logic [3:0] info, input int rdelay, input bit err);
    logic [127:0] ed;
    logic [ADDR_W-1:0] held;
    int old_wp;
    @(posedge clk); #2;
    cmp_valid = 1'b1; cmp_code = code; cmp_info = info;
    @(negedge clk);
    while (!cmp_ready) @(negedge clk);
    ed = '0;
    ed[31:28] = code;
    ed[27:24] = info;
    q_addr.push_back(m_base + ADDR_W'(m_wp));
    q_data.push_back(ed);
    @(posedge clk); #2;
    cmp_valid = 1'b0;
    held = mw_addr;
    for (int i = 0; i < rdelay; i++) begin
      @(negedge clk);
      chk(mw_valid === 1'b1 && mw_addr == held, "R8 request held while not ready", {127'h0, mw_valid}, 128'h1);
      chk(cmp_ready === 1'b0, "R8 no accept while busy", {127'h0, cmp_ready}, 128'h0);
      @(posedge clk); #2;
    end
    mw_ready = 1'b1;
    @(posedge clk); #2;
    mw_ready = 1'b0;
    rsp_valid = 1'b1; rsp_err = err;
    @(negedge clk);
    chk(eob_pulse === 1'b0, "R3 no eob before response", {127'h0, eob_pulse}, 128'h0);
    @(posedge clk); #2;
    rsp_valid = 1'b0; rsp_err = 1'b0;
    old_wp = m_wp;
    if (!err) begin
      m_wp = m_wp + 16;
      if (m_wp >= m_len) m_wp = m_wp - m_len;
    end
    @(negedge clk);
    if (err) begin
      chk(werr_pulse === 1'b1 && eob_pulse === 1'b0, "R7 error pulse only", {126'h0, werr_pulse, eob_pulse}, 128'h2);
      chk(wr_ptr == PTR_W'(old_wp), "R7 offset unchanged on error", {112'h0, wr_ptr}, 128'(old_wp));
    end else begin
      chk(eob_pulse === 1'b1 && werr_pulse === 1'b0, "R3 eob pulse", {126'h0, werr_pulse, eob_pulse}, 128'h1);
      chk(wr_ptr == PTR_W'(m_wp), "R3/R4 write offset", {112'h0, wr_ptr}, 128'(m_wp));
    end
    @(negedge clk);
    chk(eob_pulse === 1'b0 && werr_pulse === 1'b0, "R3 pulse lasts one cycle", {126'h0, werr_pulse, eob_pulse}, 128'h0);
  endtask

  task automatic hold_while_full(input string req);
    @(posedge clk); #2;
    cmp_valid = 1'b1; cmp_code = 4'd1; cmp_info = 4'd0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cmp_ready === 1'b0 && mw_valid === 1'b0, req, {126'h0, cmp_ready, mw_valid}, 128'h0);
    end
    @(posedge clk); #2;
    cmp_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ptr == 0, "R1 reset write offset", {112'h0, wr_ptr}, 128'h0);
    chk(cmp_ready === 1'b1, "R1 reset ready", {127'h0, cmp_ready}, 128'h1);
    chk(mw_valid === 1'b0 && eob_pulse === 1'b0 && werr_pulse === 1'b0, "R1 reset outputs idle",
        {125'h0, mw_valid, eob_pulse, werr_pulse}, 128'h0);

    // R10: offset 0x020 and an unmapped offset are not writable
    cfg_write(12'h020, 32'h30);
    cfg_write(12'h014, 32'h10);
    @(negedge clk);
    chk(wr_ptr == 0, "R10 write offset not writable", {112'h0, wr_ptr}, 128'h0);
    chk(cmp_ready === 1'b1, "R10 stray writes leave ring usable", {127'h0, cmp_ready}, 128'h1);

    // R2: program a base with both halves non-zero
    cfg_write(12'h008, 32'h1000_0000);
    cfg_write(12'h00C, 32'h0000_0002);
    m_base = 64'h0000_0002_1000_0000;

    do_event(4'd1, 4'd0, 0, 1'b0);
    do_event(4'd4, 4'hA, 2, 1'b0);
    do_event(4'd1, 4'd3, 1, 1'b1);  // R7 failed write
    do_event(4'd1, 4'd5, 0, 1'b0);
    @(negedge clk);
    chk(wr_ptr == 48, "R5 ring filled to last slot", {112'h0, wr_ptr}, 128'd48);
    hold_while_full("R5 stall while full");

    cfg_write(12'h400, 32'h10);      // R6 free one slot
    @(negedge clk);
    chk(cmp_ready === 1'b1, "R6 doorbell releases full ring", {127'h0, cmp_ready}, 128'h1);
    do_event(4'd4, 4'hF, 0, 1'b0);   // R4 wrap 48 -> 0
    @(negedge clk);
    chk(wr_ptr == 0, "R4 wrap at ring length", {112'h0, wr_ptr}, 128'h0);
    hold_while_full("R5 full after wrap");

    cfg_write(12'h400, 32'h23);      // R6 low bits cleared -> 32
    do_event(4'd1, 4'd1, 0, 1'b0);
    @(negedge clk);
    chk(cmp_ready === 1'b0, "R6 doorbell low bits ignored", {127'h0, cmp_ready}, 128'h0);

    // R4: programmable length of six records
    cfg_write(12'h010, 32'h60);
    m_len = 96;
    cfg_write(12'h400, 32'h10);
    for (int k = 0; k < 5; k++) do_event(4'(k), 4'(k + 2), k % 2, 1'b0);
    @(negedge clk);
    chk(wr_ptr == 0, "R4 wrap at programmed length", {112'h0, wr_ptr}, 128'h0);
    chk(cmp_ready === 1'b0, "R5 full at programmed length", {127'h0, cmp_ready}, 128'h0);
    chk(q_addr.size() == 0, "R9 all records observed", 128'(q_addr.size()), 128'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule